// File: doc/BRIEF.md
# Supervisor User-Page Access Checker

This block sits next to an address-translation lookup. It decides whether one memory access may proceed once its leaf page-table entry has been found. For each access it takes the current privilege mode, the access kind (instruction fetch, load or store), the translation mode (bare or paged) and the leaf entry's valid, read, write, execute and user flags. From these it works out the privilege that the access really runs at, and it returns either a grant or a page fault with a cause code that names the access kind.

The block keeps a local copy of two status controls. The first lets supervisor data accesses reach user pages. The second lets machine-mode loads and stores run at the privilege held in a separate previous-mode input. A small control write port updates both copies. A new value governs the access presented in the very next cycle, with no fence or flush. A build parameter removes supervisor support, and the user-page override then stays at zero.

Top module: `upc_user_page_check`

## Requirements
- R1: Privilege and previous-mode encodings are 00 user, 01 supervisor and 11 machine, and 10 is treated as machine. Access kinds are 00 fetch, 01 load and 10 store, and 11 is treated as store. An access presented with `acc_valid_i` high has its result on the outputs one clock later, with `res_valid_o` high in exactly that cycle.
- R2: When `paged_i` is 0, every access is granted and no page flag is examined.
- R3: Fetches always run at `priv_i`. A load or store issued in machine mode with the modify-privilege copy set runs at `mpp_i`. Any access whose effective privilege is machine is granted.
- R4: For an effective-supervisor load or store under paging to a page with U=1, a fault is raised when the user-page override copy is 0.
- R5: With the override at 1, the R4 access is granted if the entry is valid and its R flag (load) or W flag (store) is set.
- R6: A user-mode access under paging to a page with U=0 always faults.
- R7: A supervisor fetch under paging from a page with U=1 always faults, whatever the override holds.
- R8: Under paging with a non-machine effective privilege, the access faults if V=0, if a fetch lacks X, if a load lacks R or if a store lacks W.
- R9: The cause is 01 for a fetch fault, 10 for a load fault, 11 for a store fault and 00 on a grant. In a result cycle exactly one of `allow_o` and `fault_o` is high.
- R10: A control write on a rising edge updates `sum_o` and `mprv_o` at that edge. The access presented in the following cycle uses the new values. Both copies reset to 0.
- R11: With `HAS_SMODE` = 0, `sum_o` always reads 0 and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Write strobe for the control copies |
| csr_sum_i | input | 1 | New user-page override value |
| csr_mprv_i | input | 1 | New modify-privilege value |
| mpp_i | input | 2 | Previous-mode field used when modify-privilege is set |
| priv_i | input | 2 | Current privilege mode |
| paged_i | input | 1 | 1 when translation is paged, 0 when bare |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_type_i | input | 2 | Access kind |
| pte_v_i | input | 1 | Leaf entry valid flag |
| pte_r_i | input | 1 | Leaf entry read flag |
| pte_w_i | input | 1 | Leaf entry write flag |
| pte_x_i | input | 1 | Leaf entry execute flag |
| pte_u_i | input | 1 | Leaf entry user flag |
| sum_o | output | 1 | Current user-page override copy |
| mprv_o | output | 1 | Current modify-privilege copy |
| res_valid_o | output | 1 | Result present |
| allow_o | output | 1 | Access granted |
| fault_o | output | 1 | Page fault raised |
| cause_o | output | 2 | Fault cause code |

## Verification
Each verdict is due one clock after its access. The control copies become visible on the edge that takes the write, so an access driven in the next cycle must already see them. The driver changes inputs on falling edges and queues each expected verdict as it drives the access. The monitor pops that verdict on the following falling edge, when `res_valid_o` is high. A result with no queued entry, or a queued entry left over at the end, counts as a latency error. Every sweep step writes the controls and then issues its first access in the very next cycle, so the next-cycle rule of R10 is exercised on every write.

// File: rtl/upc_pkg.sv
package upc_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [1:0] ACC_FETCH = 2'b00;
  localparam logic [1:0] ACC_LOAD  = 2'b01;
  localparam logic [1:0] ACC_STORE = 2'b10;

  localparam logic [1:0] CAUSE_NONE = 2'b00;
  localparam logic [1:0] CAUSE_IPF  = 2'b01;
  localparam logic [1:0] CAUSE_LPF  = 2'b10;
  localparam logic [1:0] CAUSE_SPF  = 2'b11;

  typedef struct packed {
    logic v;
    logic r;
    logic w;
    logic x;
    logic u;
  } pte_flags_t;
endpackage

// File: rtl/upc_status_regs.sv
module upc_status_regs #(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic sum_i,
  input  logic mprv_i,
  output logic sum_o,
  output logic mprv_o
);
  logic mprv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mprv_q <= 1'b0;
    else if (we_i) mprv_q <= mprv_i;
  end

  generate
    if (HAS_SMODE) begin : g_sum
      logic sum_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   sum_q <= 1'b0;
        else if (we_i) sum_q <= sum_i;
      end
      assign sum_o = sum_q;
    end else begin : g_nosum
      assign sum_o = 1'b0;
    end
  endgenerate

  assign mprv_o = mprv_q;

  AST_SUM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sum_o == ($past(sum_i) & HAS_SMODE)); // R10
  AST_MPRV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mprv_o)); // R10
  AST_SUM_ABSENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_SMODE |-> !sum_o); // R11
endmodule

// File: rtl/upc_eff_priv.sv
module upc_eff_priv
  import upc_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic [1:0] acc_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  output logic [1:0] eff_o
);
  logic [1:0] sel;

  // only data accesses issued in machine mode honour the previous-mode field
  always_comb begin
    sel = priv_i;
    if (acc_i != ACC_FETCH && priv_i[1] && mprv_i) sel = mpp_i;
    eff_o = sel[1] ? PRIV_M : sel;
  end
endmodule

// File: rtl/upc_perm_eval.sv
module upc_perm_eval
  import upc_pkg::*;
(
  input  logic [1:0] eff_i,
  input  logic [1:0] acc_i,
  input  logic       paged_i,
  input  logic       sum_i,
  input  pte_flags_t flags_i,
  output logic       fault_o,
  output logic [1:0] cause_o
);
  logic is_fetch, is_load, priv_bad, perm_bad;

  assign is_fetch = (acc_i == ACC_FETCH);
  assign is_load  = (acc_i == ACC_LOAD);

  always_comb begin
    priv_bad = 1'b0;
    unique case (eff_i)
      PRIV_U:  priv_bad = !flags_i.u;
      PRIV_S:  priv_bad = is_fetch ? flags_i.u : (flags_i.u && !sum_i);
      default: priv_bad = 1'b0;
    endcase
  end

  always_comb begin
    if (is_fetch)     perm_bad = !flags_i.x;
    else if (is_load) perm_bad = !flags_i.r;
    else              perm_bad = !flags_i.w;
  end

  assign fault_o = paged_i && (eff_i != PRIV_M) && (!flags_i.v || priv_bad || perm_bad);

  always_comb begin
    if (!fault_o)     cause_o = CAUSE_NONE;
    else if (is_fetch) cause_o = CAUSE_IPF;
    else if (is_load)  cause_o = CAUSE_LPF;
    else               cause_o = CAUSE_SPF;
  end
endmodule

// File: rtl/upc_user_page_check.sv
module upc_user_page_check
  import upc_pkg::*;
#(
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       csr_we_i,
  input  logic       csr_sum_i,
  input  logic       csr_mprv_i,
  input  logic [1:0] mpp_i,
  input  logic [1:0] priv_i,
  input  logic       paged_i,
  input  logic       acc_valid_i,
  input  logic [1:0] acc_type_i,
  input  logic       pte_v_i,
  input  logic       pte_r_i,
  input  logic       pte_w_i,
  input  logic       pte_x_i,
  input  logic       pte_u_i,
  output logic       sum_o,
  output logic       mprv_o,
  output logic       res_valid_o,
  output logic       allow_o,
  output logic       fault_o,
  output logic [1:0] cause_o
);
  logic       sum_q, mprv_q, fault_c;
  logic [1:0] eff, cause_c;
  pte_flags_t flags;
  logic       valid_q, allow_q, fault_q;
  logic [1:0] cause_q;

  assign flags = '{v: pte_v_i, r: pte_r_i, w: pte_w_i, x: pte_x_i, u: pte_u_i};

  upc_status_regs #(.HAS_SMODE(HAS_SMODE)) u_regs (
    .clk_i (clk_i), .rst_ni(rst_ni), .we_i(csr_we_i),
    .sum_i (csr_sum_i), .mprv_i(csr_mprv_i),
    .sum_o (sum_q), .mprv_o(mprv_q)
  );

  upc_eff_priv u_eff (
    .priv_i(priv_i), .acc_i(acc_type_i), .mprv_i(mprv_q),
    .mpp_i (mpp_i), .eff_o(eff)
  );

  upc_perm_eval u_perm (
    .eff_i (eff), .acc_i(acc_type_i), .paged_i(paged_i), .sum_i(sum_q),
    .flags_i(flags), .fault_o(fault_c), .cause_o(cause_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      allow_q <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      valid_q <= acc_valid_i;
      allow_q <= acc_valid_i && !fault_c;
      fault_q <= acc_valid_i && fault_c;
      cause_q <= acc_valid_i ? cause_c : CAUSE_NONE;
    end
  end

  assign sum_o       = sum_q;
  assign mprv_o      = mprv_q;
  assign res_valid_o = valid_q;
  assign allow_o     = allow_q;
  assign fault_o     = fault_q;
  assign cause_o     = cause_q;

  AST_RESULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> res_valid_o); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !res_valid_o && !allow_o && !fault_o); // R1
  AST_BARE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !paged_i |=> allow_o); // R2
  AST_MACHINE_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && priv_i == PRIV_M && (acc_type_i == ACC_FETCH || !mprv_o || mpp_i == PRIV_M)
    |=> allow_o); // R3
  AST_SUM_CLEAR_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && paged_i && pte_u_i && !sum_o && acc_type_i != ACC_FETCH &&
    (priv_i == PRIV_S || (priv_i == PRIV_M && mprv_o && mpp_i == PRIV_S)) |=> fault_o); // R4
  AST_USER_KPAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && paged_i && priv_i == PRIV_U && !pte_u_i |=> fault_o); // R6
  AST_SFETCH_UPAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && paged_i && priv_i == PRIV_S && acc_type_i == ACC_FETCH && pte_u_i
    |=> fault_o); // R7
  AST_INVALID_PTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && paged_i && !pte_v_i && priv_i != PRIV_M |=> fault_o); // R8
  AST_VERDICT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (allow_o ^ fault_o)); // R9
  AST_FETCH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_type_i == ACC_FETCH |=> fault_o == (cause_o == CAUSE_IPF)); // R9
endmodule

// File: tb/tb_upc_user_page_check.sv
`timescale 1ns/1ps
module tb_upc_user_page_check;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_we = 1'b0, csr_sum = 1'b0, csr_mprv = 1'b0;
  logic [1:0] mpp = 2'b00, priv = 2'b00, acc_type = 2'b00;
  logic       paged = 1'b0, acc_valid = 1'b0;
  logic       pv = 1'b0, pr = 1'b0, pw = 1'b0, px = 1'b0, pu = 1'b0;
  logic       sum_o, mprv_o, res_valid, allow, fault;
  logic [1:0] cause;
  logic       n_sum, n_mprv, n_valid, n_allow, n_fault;
  logic [1:0] n_cause;

  int n_checks = 0;
  int n_fails  = 0;
  logic m_sum = 1'b0, m_mprv = 1'b0;

  typedef struct {
    logic [1:0] cause;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  upc_user_page_check dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_sum_i(csr_sum),
    .csr_mprv_i(csr_mprv), .mpp_i(mpp), .priv_i(priv), .paged_i(paged),
    .acc_valid_i(acc_valid), .acc_type_i(acc_type), .pte_v_i(pv), .pte_r_i(pr),
    .pte_w_i(pw), .pte_x_i(px), .pte_u_i(pu), .sum_o(sum_o), .mprv_o(mprv_o),
    .res_valid_o(res_valid), .allow_o(allow), .fault_o(fault), .cause_o(cause)
  );

  upc_user_page_check #(.HAS_SMODE(1'b0)) dut_nos (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(csr_we), .csr_sum_i(csr_sum),
    .csr_mprv_i(csr_mprv), .mpp_i(mpp), .priv_i(priv), .paged_i(paged),
    .acc_valid_i(acc_valid), .acc_type_i(acc_type), .pte_v_i(pv), .pte_r_i(pr),
    .pte_w_i(pw), .pte_x_i(px), .pte_u_i(pu), .sum_o(n_sum), .mprv_o(n_mprv),
    .res_valid_o(n_valid), .allow_o(n_allow), .fault_o(n_fault), .cause_o(n_cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference verdict: returns cause (0 = grant) and the deciding rule
  function automatic logic [1:0] ref_eval(input logic [1:0] p, input logic [1:0] a,
      input logic mp, input logic [1:0] pp, input logic s, input logic pg,
      input logic v, input logic r, input logic w, input logic x, input logic u,
      output string tag);
    logic [1:0] e;
    logic bad;
    logic [1:0] kind;
    kind = (a == 2'd0) ? 2'd1 : (a == 2'd1) ? 2'd2 : 2'd3;
    e = p;
    if (a != 2'd0 && p == 2'd3 && mp) e = pp;
    if (!pg) begin tag = "R2"; return 2'd0; end
    if (e == 2'd3) begin tag = "R3"; return 2'd0; end
    bad = 1'b0;
    tag = "R9";
    if (!v) begin bad = 1'b1; tag = "R8"; end
    else if (e == 2'd0 && !u) begin bad = 1'b1; tag = "R6"; end
    else if (e == 2'd1 && a == 2'd0 && u) begin bad = 1'b1; tag = "R7"; end
    else if (e == 2'd1 && a != 2'd0 && u && !s) begin bad = 1'b1; tag = "R4"; end
    else if ((a == 2'd0 && !x) || (a == 2'd1 && !r) || (a == 2'd2 && !w)) begin
      bad = 1'b1; tag = "R8";
    end else if (e == 2'd1 && a != 2'd0 && u) tag = "R5";
    return bad ? kind : 2'd0;
  endfunction

  task automatic write_csr(input logic s, input logic m);
    @(negedge clk);
    acc_valid = 1'b0;
    csr_we = 1'b1; csr_sum = s; csr_mprv = m;
    m_sum = s; m_mprv = m;
  endtask

  task automatic access(input logic [1:0] p, input logic [1:0] a, input logic [1:0] pp,
      input logic pg, input logic [4:0] f);
    exp_t e;
    @(negedge clk);
    // copies written in the previous cycle must already be visible
    check(sum_o == m_sum, "R10 sum copy", sum_o, m_sum);
    check(mprv_o == m_mprv, "R10 mprv copy", mprv_o, m_mprv);
    check(n_sum == 1'b0, "R11 sum absent", n_sum, 0);
    csr_we = 1'b0;
    priv = p; acc_type = a; mpp = pp; paged = pg;
    {pv, pr, pw, px, pu} = f;
    acc_valid = 1'b1;
    e.cause = ref_eval(p, a, m_mprv, pp, m_sum, pg, f[4], f[3], f[2], f[1], f[0], e.tag);
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R1 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(allow == (e.cause == 2'd0), {e.tag, " allow"}, allow, e.cause == 2'd0);
        check(fault == (e.cause != 2'd0), {e.tag, " fault"}, fault, e.cause != 2'd0);
        check(cause == e.cause, {e.tag, " R9 cause"}, cause, e.cause);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [1:0] privs [3];
    privs[0] = 2'b00; privs[1] = 2'b01; privs[2] = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    check(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
    check(sum_o == 1'b0, "R10 reset sum", sum_o, 0);
    check(mprv_o == 1'b0, "R10 reset mprv", mprv_o, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        write_csr(s[0], m[0]);
        for (int pi = 0; pi < 3; pi++)
          for (int qi = 0; qi < 3; qi++)
            for (int pg = 0; pg < 2; pg++)
              for (int a = 0; a < 3; a++)
                for (int f = 0; f < 32; f++)
                  access(privs[pi], a[1:0], privs[qi], pg[0], f[4:0]);
      end
    end

    // directed: override flips between back-to-back supervisor loads of a user page
    write_csr(1'b0, 1'b0);
    access(2'b01, 2'b01, 2'b00, 1'b1, 5'b11111);  // R4 fault
    write_csr(1'b1, 1'b0);
    access(2'b01, 2'b01, 2'b00, 1'b1, 5'b11111);  // R5 grant
    access(2'b01, 2'b10, 2'b00, 1'b1, 5'b11011);  // R8 store without W
    write_csr(1'b0, 1'b1);
    access(2'b11, 2'b10, 2'b01, 1'b1, 5'b11111);  // R4 via previous mode
    access(2'b11, 2'b00, 2'b01, 1'b1, 5'b00000);  // R3 fetch ignores previous mode

    @(negedge clk);
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R1 pending results", sb.size(), 0);
    check(n_mprv == m_mprv, "R11 mprv kept", n_mprv, m_mprv);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule